// File: doc/BRIEF.md
# Dual-Clock Deserializing Input FIFO

This block moves data that has been captured close to the pins into the core clock domain. It has ten channels that share one write enable, one read enable and one set of flags. Eight channels take 4 bits per write and two channels (5 and 6) take 8 bits per write. Every channel presents 8 bits on the read side. The write clock and the read clock are fully independent. Pointers cross between the domains as Gray codes through two-flop synchronisers.

A static parameter `PACK_EN` selects the behaviour. When it is 1 (the default), the block deserialises by two: two accepted writes are merged into one stored 8-bit entry per channel, so entries are 80 bits wide. When it is 0, every write becomes one entry, and data comes out at the rate it went in. The write side holds a two-state pairing machine. `PAIR_LO` waits for the first nibble of a pair. An accepted write in that state is the *capture* transition to `PAIR_HI`. An accepted write in `PAIR_HI` is the *commit* transition back to `PAIR_LO`, and it writes the entry and advances the write pointer. In pass-through mode the machine is not built. The almost-empty and almost-full thresholds are parameters with the value 1 or 2.

Top module: `infifo_deser`

## Requirements
- R1: With PACK_EN=0, each write stores one entry. On read, a 4-bit channel c returns its nibble in rd_data[8c+3:8c] with rd_data[8c+7:8c+4] zero. Channels 5 and 6 return all 8 bits written.
- R2: With PACK_EN=1, each channel stores the nibble from the first write of a pair in bits [3:0] of its 8-bit read field and the nibble from the second write in bits [7:4]. Channels 5 and 6 pack only the low nibble of their 8-bit input.
- R3: With PACK_EN=1, one accepted write does not make the FIFO non-empty. The write pointer advances only on the second accepted write of a pair.
- R4: The FIFO holds exactly DEPTH (default 8) entries. full is high in the write domain once DEPTH entries are stored.
- R5: A write while full is ignored. The stored contents, the write pointer and the pairing state are unchanged, so later reads return only the data accepted before full.
- R6: A read while empty is ignored. rd_data and the read pointer keep their values.
- R7: almost_empty is high when the number of stored entries is less than or equal to AE_TH (1 or 2). The count is judged in the read domain.
- R8: almost_full is high when the free space is less than or equal to AF_TH (1 or 2). The free space is judged in the write domain.
- R9: arst is active high and asynchronous. While it is high, the block shows empty=1, almost_empty=1, full=0, almost_full=0 and rd_data=0, without waiting for a clock edge.
- R10: rd_data is loaded on the rd_clk edge where rd_en is high and empty is low. Entries come out in the order they were written.
- R11: Each pointer moves by exactly one entry per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| arst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Write request, sampled on wr_clk |
| rd_en | input | 1 | Read request, sampled on rd_clk |
| wr_data | input | 48 | Channels 0-4 at [4c+3:4c], ch5 [27:20], ch6 [35:28], ch7 [39:36], ch8 [43:40], ch9 [47:44] |
| rd_data | output | 80 | Channel c at [8c+7:8c], registered |
| empty | output | 1 | No entries stored (read domain) |
| full | output | 1 | DEPTH entries stored (write domain) |
| almost_empty | output | 1 | Stored entries at or below AE_TH |
| almost_full | output | 1 | Free entries at or below AF_TH |

## Verification
The bound checker watches the pointers on every edge of their own clocks. It checks that each pointer steps by one, that a write into a full FIFO or a read from an empty one leaves the pointers, the pairing state and rd_data untouched, and that in packing mode the write pointer moves only out of the holding state. Some behaviour can only be shown by the bench's write and read sequences: the nibble placement within each channel's read field, the zero upper nibbles in pass-through mode, and the flag thresholds after the synchroniser delay. The same holds for the absence of overflowed data in later reads and the flags forced by an asynchronous reset with no clock edge.

// File: rtl/infifo_pkg.sv
package infifo_pkg;
    localparam int NCH    = 10;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int WIDE_A = 5;
    localparam int WIDE_B = 6;

    typedef enum logic {
        PAIR_LO = 1'b0,
        PAIR_HI = 1'b1
    } pair_state_t;

    function automatic bit ch_is_wide(input int c);
        return (c == WIDE_A) || (c == WIDE_B);
    endfunction

    function automatic int ch_in_w(input int c);
        return ch_is_wide(c) ? BYTE_W : NIB_W;
    endfunction

    // bit offset of channel c inside the packed write bus
    function automatic int ch_in_off(input int c);
        int s;
        s = 0;
        for (int i = 0; i < c; i++) s += ch_in_w(i);
        return s;
    endfunction

    localparam int IN_W  = ch_in_off(NCH);
    localparam int OUT_W = NCH * BYTE_W;
endpackage

// File: rtl/infifo_sync.sv
module infifo_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/infifo_mem.sv
module infifo_mem #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 80,
    parameter int AW    = 3
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/infifo_wr.sv
module infifo_wr
    import infifo_pkg::*;
#(
    parameter bit PACK_EN = 1'b1,
    parameter int DEPTH   = 8,
    parameter int AF_TH   = 1,
    parameter int PTR_W   = 4,
    parameter int ENT_W   = 80
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             wr_en,
    input  logic [IN_W-1:0]  din,
    input  logic [PTR_W-1:0] rq_gray,
    output logic             mem_we,
    output logic [PTR_W-2:0] mem_addr,
    output logic [ENT_W-1:0] mem_wdata,
    output logic [PTR_W-1:0] wptr_bin,
    output logic [PTR_W-1:0] wptr_gray,
    output logic             full,
    output logic             almost_full,
    output logic             pair_hi
);
    localparam int AW = PTR_W - 1;

    logic             accept;
    logic [PTR_W-1:0] rq_bin;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] wptr_nxt;

    always_comb begin
        rq_bin[PTR_W-1] = rq_gray[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) rq_bin[i] = rq_bin[i+1] ^ rq_gray[i];
    end

    always_comb begin
        used        = wptr_bin - rq_bin;
        full        = (used == PTR_W'(DEPTH));
        almost_full = ((PTR_W'(DEPTH) - used) <= PTR_W'(AF_TH));
    end

    assign accept   = wr_en & ~full;
    assign mem_addr = wptr_bin[AW-1:0];
    assign wptr_nxt = mem_we ? wptr_bin + PTR_W'(1) : wptr_bin;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            wptr_bin  <= '0;
            wptr_gray <= '0;
        end else begin
            wptr_bin  <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    generate
        if (PACK_EN) begin : g_pack
            pair_state_t             st_q, st_d;
            logic [NCH*NIB_W-1:0]    lo_q;
            logic [NCH*NIB_W-1:0]    nib_in;
            logic [2*NIB_W-1:0]      unused_hi;

            for (genvar c = 0; c < NCH; c++) begin : g_nib
                localparam int OFF = ch_in_off(c);
                assign nib_in[c*NIB_W +: NIB_W] = din[OFF +: NIB_W];
            end
            assign unused_hi = {din[ch_in_off(WIDE_A)+NIB_W +: NIB_W],
                                din[ch_in_off(WIDE_B)+NIB_W +: NIB_W]};

            // state register and first-nibble holding register
            always_ff @(posedge clk or posedge arst) begin
                if (arst) begin
                    st_q <= PAIR_LO;
                    lo_q <= '0;
                end else begin
                    st_q <= st_d;
                    if (accept && (st_q == PAIR_LO)) lo_q <= nib_in;
                end
            end

            // next state: capture (LO->HI) and commit (HI->LO)
            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    PAIR_LO: if (accept) st_d = PAIR_HI;
                    PAIR_HI: if (accept) st_d = PAIR_LO;
                    default: st_d = PAIR_LO;
                endcase
            end

            // outputs of the pairing machine
            always_comb begin
                mem_we  = 1'b0;
                pair_hi = 1'b0;
                unique case (st_q)
                    PAIR_LO: pair_hi = 1'b0;
                    PAIR_HI: begin
                        pair_hi = 1'b1;
                        mem_we  = accept;
                    end
                    default: mem_we = 1'b0;
                endcase
            end

            for (genvar c = 0; c < NCH; c++) begin : g_ent
                assign mem_wdata[c*BYTE_W +: BYTE_W] =
                    {nib_in[c*NIB_W +: NIB_W], lo_q[c*NIB_W +: NIB_W]};
            end
        end else begin : g_pass
            assign mem_we    = accept;
            assign mem_wdata = din;
            assign pair_hi   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/infifo_rd.sv
module infifo_rd
    import infifo_pkg::*;
#(
    parameter bit PACK_EN = 1'b1,
    parameter int AE_TH   = 1,
    parameter int PTR_W   = 4,
    parameter int ENT_W   = 80
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] wq_gray,
    input  logic [ENT_W-1:0] rentry,
    output logic [PTR_W-2:0] mem_addr,
    output logic [PTR_W-1:0] rptr_bin,
    output logic [PTR_W-1:0] rptr_gray,
    output logic             empty,
    output logic             almost_empty,
    output logic [OUT_W-1:0] rd_data
);
    localparam int AW = PTR_W - 1;

    logic             accept;
    logic [PTR_W-1:0] wq_bin;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] rptr_nxt;
    logic [OUT_W-1:0] shaped;

    always_comb begin
        wq_bin[PTR_W-1] = wq_gray[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) wq_bin[i] = wq_bin[i+1] ^ wq_gray[i];
    end

    always_comb begin
        used         = wq_bin - rptr_bin;
        empty        = (used == '0);
        almost_empty = (used <= PTR_W'(AE_TH));
    end

    assign accept   = rd_en & ~empty;
    assign mem_addr = rptr_bin[AW-1:0];
    assign rptr_nxt = accept ? rptr_bin + PTR_W'(1) : rptr_bin;

    generate
        if (PACK_EN) begin : g_pack
            assign shaped = rentry;
        end else begin : g_pass
            for (genvar c = 0; c < NCH; c++) begin : g_ch
                localparam int OFF = ch_in_off(c);
                if (ch_is_wide(c)) begin : g_wide
                    assign shaped[c*BYTE_W +: BYTE_W] = rentry[OFF +: BYTE_W];
                end else begin : g_narrow
                    assign shaped[c*BYTE_W +: BYTE_W] = {{NIB_W{1'b0}}, rentry[OFF +: NIB_W]};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            rptr_bin  <= '0;
            rptr_gray <= '0;
            rd_data   <= '0;
        end else begin
            rptr_bin  <= rptr_nxt;
            rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            if (accept) rd_data <= shaped;
        end
    end
endmodule

// File: rtl/infifo_deser.sv
module infifo_deser
    import infifo_pkg::*;
#(
    parameter bit PACK_EN     = 1'b1,
    parameter int DEPTH       = 8,
    parameter int AE_TH       = 1,
    parameter int AF_TH       = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             arst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IN_W-1:0]  wr_data,
    output logic [OUT_W-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);
    localparam int PTR_W = $clog2(DEPTH) + 1;
    localparam int AW    = PTR_W - 1;
    localparam int ENT_W = PACK_EN ? OUT_W : IN_W;

    logic             mem_we;
    logic [AW-1:0]    waddr, raddr;
    logic [ENT_W-1:0] wentry, rentry;
    logic [PTR_W-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    logic [PTR_W-1:0] rq_gray_wr, wq_gray_rd;
    logic             pair_hi;

    infifo_wr #(
        .PACK_EN(PACK_EN), .DEPTH(DEPTH), .AF_TH(AF_TH), .PTR_W(PTR_W), .ENT_W(ENT_W)
    ) u_wr (
        .clk(wr_clk), .arst(arst), .wr_en(wr_en), .din(wr_data), .rq_gray(rq_gray_wr),
        .mem_we(mem_we), .mem_addr(waddr), .mem_wdata(wentry),
        .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
        .full(full), .almost_full(almost_full), .pair_hi(pair_hi)
    );

    infifo_mem #(.DEPTH(DEPTH), .ENT_W(ENT_W), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wentry),
        .raddr(raddr), .rdata(rentry)
    );

    infifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
        .clk(wr_clk), .arst(arst), .d(rptr_gray), .q(rq_gray_wr)
    );

    infifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
        .clk(rd_clk), .arst(arst), .d(wptr_gray), .q(wq_gray_rd)
    );

    infifo_rd #(
        .PACK_EN(PACK_EN), .AE_TH(AE_TH), .PTR_W(PTR_W), .ENT_W(ENT_W)
    ) u_rd (
        .clk(rd_clk), .arst(arst), .rd_en(rd_en), .wq_gray(wq_gray_rd), .rentry(rentry),
        .mem_addr(raddr), .rptr_bin(rptr_bin), .rptr_gray(rptr_gray),
        .empty(empty), .almost_empty(almost_empty), .rd_data(rd_data)
    );
endmodule

// File: rtl/infifo_deser_chk.sv
module infifo_deser_chk #(
    parameter bit PACK_EN = 1'b1,
    parameter int PTR_W   = 4,
    parameter int OUT_W   = 80
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             arst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             full,
    input logic             empty,
    input logic             pair_hi,
    input logic [PTR_W-1:0] wptr,
    input logic [PTR_W-1:0] rptr,
    input logic [OUT_W-1:0] rd_data
);
    assert_wptr_step_R11: assert property (@(posedge wr_clk) disable iff (arst)
        (wptr != $past(wptr)) |-> (wptr == $past(wptr) + PTR_W'(1)));

    assert_rptr_step_R11: assert property (@(posedge rd_clk) disable iff (arst)
        (rptr != $past(rptr)) |-> (rptr == $past(rptr) + PTR_W'(1)));

    assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (arst)
        (full && wr_en) |=> ($stable(wptr) && $stable(pair_hi)));

    assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (arst)
        (empty && rd_en) |=> ($stable(rptr) && $stable(rd_data)));

    assert_rd_advance_R10: assert property (@(posedge rd_clk) disable iff (arst)
        (rptr != $past(rptr)) |-> $past(rd_en && !empty));

    generate
        if (PACK_EN) begin : g_pack_chk
            assert_pair_commit_R3: assert property (@(posedge wr_clk) disable iff (arst)
                (wptr != $past(wptr)) |-> $past(pair_hi));
        end
    endgenerate
endmodule

bind infifo_deser infifo_deser_chk #(
    .PACK_EN(PACK_EN), .PTR_W(PTR_W), .OUT_W(infifo_pkg::OUT_W)
) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst(arst), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .pair_hi(pair_hi),
    .wptr(wptr_bin), .rptr(rptr_bin), .rd_data(rd_data)
);

// File: tb/infifo_deser_tb_top.sv
module infifo_deser_tb_top;
    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic arst   = 1'b1;
    logic [47:0] wr_data = '0;
    logic wr_en_a = 1'b0, rd_en_a = 1'b0, wr_en_b = 1'b0, rd_en_b = 1'b0;
    logic [79:0] rd_data_a, rd_data_b;
    logic empty_a, full_a, ae_a, af_a, empty_b, full_b, ae_b, af_b;
    int total = 0;
    int bad   = 0;

    always #10 wr_clk = ~wr_clk;   // 50 MHz
    always #17 rd_clk = ~rd_clk;

    // packing mode, thresholds 1
    infifo_deser dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .arst(arst), .wr_en(wr_en_a), .rd_en(rd_en_a),
        .wr_data(wr_data), .rd_data(rd_data_a), .empty(empty_a), .full(full_a),
        .almost_empty(ae_a), .almost_full(af_a)
    );

    // pass-through mode, thresholds 2
    infifo_deser #(.PACK_EN(1'b0), .AE_TH(2), .AF_TH(2)) dut_pass_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .arst(arst), .wr_en(wr_en_b), .rd_en(rd_en_b),
        .wr_data(wr_data), .rd_data(rd_data_b), .empty(empty_b), .full(full_b),
        .almost_empty(ae_b), .almost_full(af_b)
    );

    localparam logic [47:0] VEC [0:7] = '{
        48'h9A3C_E5F1_7B26, 48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'h1234_5678_9ABC,
        48'hA5A5_5A5A_C3C3, 48'h0F0F_F0F0_1E2D, 48'h8421_1248_7EDB, 48'h6C3F_09D4_B2E8
    };

    function automatic int in_w(input int c);
        return (c == 5 || c == 6) ? 8 : 4;
    endfunction

    function automatic int in_off(input int c);
        int s = 0;
        for (int i = 0; i < c; i++) s += in_w(i);
        return s;
    endfunction

    function automatic logic [79:0] exp_pass(input logic [47:0] v);
        logic [79:0] r = '0;
        for (int c = 0; c < 10; c++) begin
            if (in_w(c) == 8) r[c*8 +: 8] = v[in_off(c) +: 8];
            else              r[c*8 +: 8] = {4'h0, v[in_off(c) +: 4]};
        end
        return r;
    endfunction

    function automatic logic [79:0] exp_pack(input logic [47:0] a, input logic [47:0] b);
        logic [79:0] r = '0;
        for (int c = 0; c < 10; c++) r[c*8 +: 8] = {b[in_off(c) +: 4], a[in_off(c) +: 4]};
        return r;
    endfunction

    function automatic logic [47:0] pat(input int k);
        return {6{8'(k * 29 + 7)}};
    endfunction

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_a(input logic [47:0] v);
        @(negedge wr_clk); wr_data = v; wr_en_a = 1'b1;
        @(negedge wr_clk); wr_en_a = 1'b0;
    endtask

    task automatic wr_b(input logic [47:0] v);
        @(negedge wr_clk); wr_data = v; wr_en_b = 1'b1;
        @(negedge wr_clk); wr_en_b = 1'b0;
    endtask

    task automatic rd_a;
        @(negedge rd_clk); rd_en_a = 1'b1;
        @(negedge rd_clk); rd_en_a = 1'b0;
    endtask

    task automatic rd_b;
        @(negedge rd_clk); rd_en_b = 1'b1;
        @(negedge rd_clk); rd_en_b = 1'b0;
    endtask

    task automatic settle;
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (10) @(negedge wr_clk);
        arst = 1'b0;
        settle();
        // R9: state after reset
        chk("R9 empty", 80'(empty_a), 80'(1));
        chk("R9 full", 80'(full_a), 80'(0));
        chk("R9 almost_empty", 80'(ae_a), 80'(1));
        chk("R9 almost_full", 80'(af_a), 80'(0));
        chk("R9 rd_data", rd_data_a, 80'(0));

        // table walk on pass-through: flags after each write (R4 R7 R8)
        for (int k = 0; k < 8; k++) begin
            wr_b(VEC[k]);
            settle();
            chk("R7 ae thresh2", 80'(ae_b), 80'((k + 1) <= 2));
            chk("R8 af thresh2", 80'(af_b), 80'((8 - (k + 1)) <= 2));
            chk("R4 full", 80'(full_b), 80'(k == 7));
        end
        wr_b(48'hDEAD_BEEF_0BAD);   // R5: dropped
        settle();
        chk("R5 full held", 80'(full_b), 80'(1));
        for (int k = 0; k < 8; k++) begin
            rd_b();
            chk("R1 R10 pass data", rd_data_b, exp_pass(VEC[k]));
        end
        chk("R5 empty after 8", 80'(empty_b), 80'(1));
        rd_b();   // R6: ignored
        chk("R6 rd_data hold", rd_data_b, exp_pass(VEC[7]));
        wr_b(VEC[3]);
        settle();
        rd_b();
        chk("R6 pointer intact", rd_data_b, exp_pass(VEC[3]));

        // packing mode
        wr_a(VEC[0]);
        settle();
        chk("R3 one nibble still empty", 80'(empty_a), 80'(1));
        wr_a(VEC[1]);
        settle();
        chk("R3 pair commits", 80'(empty_a), 80'(0));
        chk("R7 ae one entry", 80'(ae_a), 80'(1));
        for (int k = 2; k < 8; k++) wr_a(VEC[k]);
        settle();
        chk("R7 ae four entries", 80'(ae_a), 80'(0));
        chk("R8 af four entries", 80'(af_a), 80'(0));
        for (int j = 0; j < 4; j++) begin
            rd_a();
            chk("R2 packed data", rd_data_a, exp_pack(VEC[2*j], VEC[2*j+1]));
        end
        chk("R10 empty after drain", 80'(empty_a), 80'(1));

        for (int k = 0; k < 16; k++) begin
            wr_a(pat(k));
            if (k == 11) begin
                settle();
                chk("R8 af six entries", 80'(af_a), 80'(0));
            end
            if (k == 13) begin
                settle();
                chk("R8 af seven entries", 80'(af_a), 80'(1));
                chk("R4 not full at seven", 80'(full_a), 80'(0));
            end
        end
        settle();
        chk("R4 full at eight", 80'(full_a), 80'(1));
        wr_a(pat(20));
        wr_a(pat(21));
        settle();
        for (int j = 0; j < 8; j++) begin
            rd_a();
            chk("R5 R10 packed order", rd_data_a, exp_pack(pat(2*j), pat(2*j+1)));
        end
        chk("R5 empty, no overflow data", 80'(empty_a), 80'(1));
        wr_a(pat(30));
        wr_a(pat(31));
        settle();
        rd_a();
        chk("R5 pairing state intact", rd_data_a, exp_pack(pat(30), pat(31)));

        // asynchronous reset between clock edges
        wr_a(pat(40));
        wr_a(pat(41));
        settle();
        chk("R9 pre-reset nonempty", 80'(empty_a), 80'(0));
        @(negedge wr_clk);
        #3 arst = 1'b1;
        #1;
        chk("R9 async empty", 80'(empty_a), 80'(1));
        chk("R9 async full", 80'(full_a), 80'(0));
        chk("R9 async rd_data", rd_data_a, 80'(0));
        repeat (6) @(negedge wr_clk);
        arst = 1'b0;
        settle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule